// File: doc/BRIEF.md
# Slave Video Timing Decoder

This block sits at the front of a video encoder and recovers frame, field and line timing from a source that drives the encoder's timing. The timing can arrive as four-byte timing codes embedded in the 8-bit multiplexed pixel stream, or as separate horizontal and field/vertical sync pins. In each case the block produces a field parity level, one-cycle pulses at each new frame and each new line, a running line number within the frame, and a blanking flag for the downstream pixel path.

A 3-bit mode input picks how frames and fields are decoded. Bit 0 selects master operation. Master timing generation is handled elsewhere, so with bit 0 set this block stays quiet. The blanking flag comes either from the external blank pin (or, in embedded-code mode, from the code flags) or from the block's own line count. The line counter wraps after 525 or 625 lines, as set by a standard-select input. It can be cleared by taking a control bit high and then low.

Top module: `vsd_slave_decoder`

## Requirements
- R1: With mode 3'b000, a byte sequence FF, 00, 00, XY where XY bit 7 is 1 is a timing code. XY bit 6 is the field flag, bit 5 the vertical flag and bit 4 the horizontal flag (1 = end of active video). A code with bit 4 set pulses line_start_o in the cycle after XY is sampled, and every code loads field_o from bit 6. A sequence whose fourth byte has bit 7 clear has no effect.
- R2: With mode 3'b000, a code whose field flag is 0 while field_o is 1 pulses frame_start_o and sets line_o to 0.
- R3: With mode 3'b010, a change of fld_i while hsync_i is low pulses frame_start_o, sets line_o to 0 and loads field_o with fld_i. A change of fld_i while hsync_i is high has no effect.
- R4: With mode 3'b100, falling hsync_i and fld_i on the same clock pulse frame_start_o, set line_o to 0 and set field_o to 0. fld_i falling while hsync_i is high sets field_o to 1 with no frame pulse.
- R5: With mode 3'b110, a change of fld_i while hsync_i is high pulses frame_start_o and loads field_o with fld_i. A change while hsync_i is low has no effect.
- R6: In the three pin modes, each falling edge of hsync_i pulses line_start_o and advances line_o by one. Every pulse is one cycle wide and appears one cycle after the input edge.
- R7: With mode bit 0 set, no frame or line pulses are produced, and field_o and line_o hold.
- R8: line_o wraps to 0 after 524 when pal_i is 0, and after 624 when pal_i is 1.
- R9: With blank_en_i at 1, blank_o follows blank_i one cycle later in the pin modes. In mode 3'b000 it follows the OR of the vertical and horizontal flags of the last code.
- R10: With blank_en_i at 0, blank_o is 1 on lines 0 to 19 and 263 to 282 (NTSC), or on lines 0 to 24 and 313 to 337 (PAL), and 0 on all other lines.
- R11: ctr_rst_i held high leaves line_o unchanged. Its return to low clears line_o to 0 in the next cycle.
- R12: After reset, field_o is 0, both pulses are 0, line_o is 0 and blank_o is 1 (with blank_en_i at 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 3 | Timing mode; bit 0 = master |
| pal_i | input | 1 | 1 = 625-line standard, 0 = 525-line |
| blank_en_i | input | 1 | 1 = use external/code blanking, 0 = internal |
| ctr_rst_i | input | 1 | Counter clear control (high then low) |
| pix_i | input | 8 | Multiplexed pixel byte |
| hsync_i | input | 1 | Horizontal sync, active low |
| fld_i | input | 1 | Field level or vertical sync (active low) |
| blank_i | input | 1 | External blanking request, active high |
| field_o | output | 1 | Current field parity |
| frame_start_o | output | 1 | One-cycle pulse at frame start |
| line_start_o | output | 1 | One-cycle pulse at line start |
| line_o | output | 10 | Line number within the frame |
| blank_o | output | 1 | Blanking flag |

## Verification
A wrong edge register or mis-decoded mode shows up as a missing or extra frame or line pulse, one cycle after the offending sync edge, so it is caught on the very next sample. A corrupted line counter first shows in line_o and only later in blank_o. The bench therefore walks the counter through both blanking windows and both wrap points, so that an off-by-one boundary shows within one line. A damaged code-match register shows at once as a missing line pulse or a stale field_o right after the fourth code byte.

// File: rtl/vsd_pkg.sv
package vsd_pkg;
  // decode selection from mode bits [2:1]
  typedef enum logic [1:0] {
    SEL_CODE    = 2'b00,
    SEL_FLD_LO  = 2'b01,
    SEL_HV      = 2'b10,
    SEL_FLD_HI  = 2'b11
  } sync_sel_e;

  localparam int unsigned BYTE_W = 8;
endpackage

// File: rtl/vsd_pin_edges.sv
module vsd_pin_edges #(
  parameter int unsigned N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] sig_i,
  output logic [N-1:0] fall_o,
  output logic [N-1:0] chg_o
);
  logic [N-1:0] sig_q;

  // idle level of every sync pin is high
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sig_q <= '1;
    else         sig_q <= sig_i;
  end

  for (genvar g = 0; g < N; g++) begin : g_edge
    assign fall_o[g] = sig_q[g] & ~sig_i[g];
    assign chg_o[g]  = sig_q[g] ^ sig_i[g];
  end
endmodule

// File: rtl/vsd_code_detect.sv
module vsd_code_detect
  import vsd_pkg::*;
#(
  parameter int unsigned PRE = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BYTE_W-1:0] pix_i,
  output logic              hit_o,
  output logic              f_o,
  output logic              v_o,
  output logic              h_o
);
  logic [BYTE_W-1:0] hist_q [PRE];
  logic [PRE-1:0]    ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < PRE; i++) hist_q[i] <= '0;
    end else begin
      hist_q[0] <= pix_i;
      for (int i = 1; i < PRE; i++) hist_q[i] <= hist_q[i-1];
    end
  end

  // oldest byte is all ones, the rest all zeros
  for (genvar g = 0; g < PRE; g++) begin : g_match
    if (g == PRE - 1) begin : g_lead
      assign ok[g] = (hist_q[g] == '1);
    end else begin : g_zero
      assign ok[g] = (hist_q[g] == '0);
    end
  end

  assign hit_o = (&ok) & pix_i[7];
  assign f_o   = pix_i[6];
  assign v_o   = pix_i[5];
  assign h_o   = pix_i[4];
endmodule

// File: rtl/vsd_line_ctr.sv
module vsd_line_ctr #(
  parameter int unsigned NTSC_LINES = 525,
  parameter int unsigned PAL_LINES  = 625,
  parameter int unsigned NTSC_VBL   = 20,
  parameter int unsigned PAL_VBL    = 25,
  parameter int unsigned LW         = $clog2(PAL_LINES)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          pal_i,
  input  logic          ctr_rst_i,
  input  logic          frame_i,
  input  logic          line_i,
  output logic [LW-1:0] line_o,
  output logic          auto_blank_o
);
  localparam logic [LW-1:0] N_LAST  = LW'(NTSC_LINES - 1);
  localparam logic [LW-1:0] P_LAST  = LW'(PAL_LINES - 1);
  localparam logic [LW-1:0] N_HALF  = LW'((NTSC_LINES + 1) / 2);
  localparam logic [LW-1:0] P_HALF  = LW'((PAL_LINES + 1) / 2);
  localparam logic [LW-1:0] N_VBL   = LW'(NTSC_VBL);
  localparam logic [LW-1:0] P_VBL   = LW'(PAL_VBL);
  localparam logic [LW-1:0] N_HEND  = LW'((NTSC_LINES + 1) / 2 + NTSC_VBL);
  localparam logic [LW-1:0] P_HEND  = LW'((PAL_LINES + 1) / 2 + PAL_VBL);

  logic          ctr_q;
  logic [LW-1:0] line_q;
  logic [LW-1:0] last, half, vbl, hend;

  assign last = pal_i ? P_LAST : N_LAST;
  assign half = pal_i ? P_HALF : N_HALF;
  assign vbl  = pal_i ? P_VBL  : N_VBL;
  assign hend = pal_i ? P_HEND : N_HEND;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctr_q  <= 1'b0;
      line_q <= '0;
    end else begin
      ctr_q <= ctr_rst_i;
      if (ctr_q && !ctr_rst_i)  line_q <= '0;
      else if (frame_i)         line_q <= '0;
      else if (line_i)          line_q <= (line_q >= last) ? '0 : line_q + 1'b1;
    end
  end

  assign line_o       = line_q;
  assign auto_blank_o = (line_q < vbl) || (line_q >= half && line_q < hend);
endmodule

// File: rtl/vsd_slave_decoder.sv
module vsd_slave_decoder
  import vsd_pkg::*;
#(
  parameter int unsigned NTSC_LINES = 525,
  parameter int unsigned PAL_LINES  = 625,
  parameter int unsigned NTSC_VBL   = 20,
  parameter int unsigned PAL_VBL    = 25,
  parameter int unsigned LW         = $clog2(PAL_LINES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2:0]        mode_i,
  input  logic              pal_i,
  input  logic              blank_en_i,
  input  logic              ctr_rst_i,
  input  logic [BYTE_W-1:0] pix_i,
  input  logic              hsync_i,
  input  logic              fld_i,
  input  logic              blank_i,
  output logic              field_o,
  output logic              frame_start_o,
  output logic              line_start_o,
  output logic [LW-1:0]     line_o,
  output logic              blank_o
);
  localparam int unsigned IDX_H = 0;
  localparam int unsigned IDX_F = 1;

  logic [1:0] fall, chg;
  logic       c_hit, c_f, c_v, c_h;
  logic       slave;
  sync_sel_e  sel;
  logic       ev_frame, ev_line, ev_fld;
  logic       new_fld;
  logic       field_q, frame_q, line_q;
  logic       pin_blank_q, code_blank_q;
  logic       auto_blank;

  vsd_pin_edges #(.N(2)) u_edges (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sig_i  ({fld_i, hsync_i}),
    .fall_o (fall),
    .chg_o  (chg)
  );

  vsd_code_detect #(.PRE(3)) u_code (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pix_i  (pix_i),
    .hit_o  (c_hit),
    .f_o    (c_f),
    .v_o    (c_v),
    .h_o    (c_h)
  );

  assign slave = ~mode_i[0];
  assign sel   = sync_sel_e'(mode_i[2:1]);

  always_comb begin
    ev_frame = 1'b0;
    ev_line  = 1'b0;
    ev_fld   = 1'b0;
    new_fld  = field_q;
    unique case (sel)
      SEL_CODE: begin
        ev_line  = c_hit & c_h;
        ev_frame = c_hit & ~c_f & field_q;
        ev_fld   = c_hit;
        new_fld  = c_f;
      end
      SEL_FLD_LO: begin
        ev_line  = fall[IDX_H];
        ev_frame = chg[IDX_F] & ~hsync_i;
        ev_fld   = ev_frame;
        new_fld  = fld_i;
      end
      SEL_HV: begin
        ev_line  = fall[IDX_H];
        ev_frame = fall[IDX_H] & fall[IDX_F];
        ev_fld   = fall[IDX_F];
        new_fld  = hsync_i; // falling vsync with hsync high -> second field
      end
      SEL_FLD_HI: begin
        ev_line  = fall[IDX_H];
        ev_frame = chg[IDX_F] & hsync_i;
        ev_fld   = ev_frame;
        new_fld  = fld_i;
      end
      default: ;
    endcase
    if (!slave) begin
      ev_frame = 1'b0;
      ev_line  = 1'b0;
      ev_fld   = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      field_q      <= 1'b0;
      frame_q      <= 1'b0;
      line_q       <= 1'b0;
      pin_blank_q  <= 1'b0;
      code_blank_q <= 1'b0;
    end else begin
      frame_q     <= ev_frame;
      line_q      <= ev_line;
      pin_blank_q <= blank_i;
      if (ev_fld) field_q <= new_fld;
      if (slave && sel == SEL_CODE && c_hit) code_blank_q <= c_v | c_h;
    end
  end

  vsd_line_ctr #(
    .NTSC_LINES (NTSC_LINES),
    .PAL_LINES  (PAL_LINES),
    .NTSC_VBL   (NTSC_VBL),
    .PAL_VBL    (PAL_VBL),
    .LW         (LW)
  ) u_lines (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .pal_i        (pal_i),
    .ctr_rst_i    (ctr_rst_i),
    .frame_i      (ev_frame),
    .line_i       (ev_line),
    .line_o       (line_o),
    .auto_blank_o (auto_blank)
  );

  assign field_o       = field_q;
  assign frame_start_o = frame_q;
  assign line_start_o  = line_q;
  assign blank_o       = !blank_en_i ? auto_blank
                       : (sel == SEL_CODE) ? code_blank_q : pin_blank_q;
endmodule

// File: rtl/vsd_slave_decoder_chk.sv
module vsd_slave_decoder_chk #(
  parameter int unsigned LW = 10
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [2:0]    mode_i,
  input logic          ctr_rst_i,
  input logic          frame_start_o,
  input logic          line_start_o,
  input logic [LW-1:0] line_o
);
  // R2 R3 R4: a frame pulse always comes with line 0
  a_r2_frame_line_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_o |-> line_o == '0);

  // R8: the count only steps by one or returns to zero
  a_r8_line_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(line_o) |-> (line_o == '0 || line_o == $past(line_o) + 1'b1));

  // R6: a nonzero new line number needs a line pulse
  a_r6_line_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(line_o) && line_o != '0) |-> line_start_o);

  // R7: master selection silences both pulses
  a_r7_master_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(mode_i[0]) |-> (!frame_start_o && !line_start_o));

  // R11: release of the clear control zeroes the count
  a_r11_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(ctr_rst_i) && $past(rst_ni)) |=> line_o == '0);
endmodule

bind vsd_slave_decoder vsd_slave_decoder_chk #(.LW(LW)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .mode_i        (mode_i),
  .ctr_rst_i     (ctr_rst_i),
  .frame_start_o (frame_start_o),
  .line_start_o  (line_start_o),
  .line_o        (line_o)
);

// File: tb/vsd_slave_decoder_tb.sv
module vsd_slave_decoder_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [2:0] mode_i = 3'b100;
  logic       pal_i = 1'b0;
  logic       blank_en_i = 1'b0;
  logic       ctr_rst_i = 1'b0;
  logic [7:0] pix_i = 8'h00;
  logic       hsync_i = 1'b1;
  logic       fld_i = 1'b1;
  logic       blank_i = 1'b0;
  logic       field_o, frame_start_o, line_start_o, blank_o;
  logic [9:0] line_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  vsd_slave_decoder u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .mode_i(mode_i), .pal_i(pal_i),
    .blank_en_i(blank_en_i), .ctr_rst_i(ctr_rst_i), .pix_i(pix_i),
    .hsync_i(hsync_i), .fld_i(fld_i), .blank_i(blank_i),
    .field_o(field_o), .frame_start_o(frame_start_o),
    .line_start_o(line_start_o), .line_o(line_o), .blank_o(blank_o)
  );

  task automatic chk(input string req, input int got, input int exp);
    n_cmp++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic hpulse();
    hsync_i = 1'b0; @(negedge clk_i);
    hsync_i = 1'b1; @(negedge clk_i);
  endtask

  task automatic hpulses(input int n);
    for (int i = 0; i < n; i++) hpulse();
  endtask

  task automatic code(input logic [7:0] xy);
    pix_i = 8'hFF; @(negedge clk_i);
    pix_i = 8'h00; @(negedge clk_i);
    pix_i = 8'h00; @(negedge clk_i);
    pix_i = xy;    @(negedge clk_i);
    pix_i = 8'h10;
  endtask

  // {mode[2:0], hsync, fld, exp_frame, exp_line, exp_field, exp_line_no[9:0]}
  localparam int NV = 17;
  localparam logic [17:0] VEC [NV] = '{
    {3'b100, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 10'd1},  // R6
    {3'b100, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 10'd1},
    {3'b100, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 10'd0},  // R4 odd
    {3'b100, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 10'd0},
    {3'b100, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 10'd0},
    {3'b100, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 10'd0},  // R4 even
    {3'b100, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 10'd1},
    {3'b100, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 10'd1},
    {3'b010, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 10'd1},  // R3 ignored
    {3'b010, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 10'd2},
    {3'b010, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 10'd0},  // R3
    {3'b010, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 10'd0},
    {3'b110, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 10'd0},  // R5
    {3'b110, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 10'd1},
    {3'b110, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 10'd1},  // R5 ignored
    {3'b111, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 10'd1},  // R7
    {3'b111, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 10'd1}   // R7
  };

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got 0 expected 1 (run completed)");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R12 reset state
    chk("R12 field", field_o, 0);
    chk("R12 frame", frame_start_o, 0);
    chk("R12 line pulse", line_start_o, 0);
    chk("R12 line", line_o, 0);
    chk("R12 blank", blank_o, 1);

    for (int i = 0; i < NV; i++) begin
      mode_i  = VEC[i][17:15];
      hsync_i = VEC[i][14];
      fld_i   = VEC[i][13];
      @(negedge clk_i);
      chk($sformatf("R3-5 row%0d frame", i), frame_start_o, int'(VEC[i][12]));
      chk($sformatf("R6 row%0d line pulse", i), line_start_o, int'(VEC[i][11]));
      chk($sformatf("R4 row%0d field", i), field_o, int'(VEC[i][10]));
      chk($sformatf("R6 row%0d line", i), line_o, int'(VEC[i][9:0]));
    end

    // R1 R2 embedded codes, R9 code blanking
    mode_i = 3'b000; blank_en_i = 1'b1; pix_i = 8'h10;
    @(negedge clk_i);
    code(8'h70);
    chk("R1 bad code line pulse", line_start_o, 0);
    chk("R1 bad code line", line_o, 1);
    code(8'hF0);
    chk("R1 eav line pulse", line_start_o, 1);
    chk("R1 field", field_o, 1);
    chk("R1 line", line_o, 2);
    chk("R9 code blank on", blank_o, 1);
    code(8'hC0);
    chk("R1 sav no pulse", line_start_o, 0);
    chk("R9 code blank off", blank_o, 0);
    code(8'hB0);
    chk("R2 frame", frame_start_o, 1);
    chk("R2 field", field_o, 0);
    chk("R2 line", line_o, 0);
    @(negedge clk_i);
    chk("R2 pulse width", frame_start_o, 0);

    // R9 pin blanking
    mode_i = 3'b010; hsync_i = 1'b1; fld_i = 1'b0; blank_i = 1'b1;
    @(negedge clk_i);
    chk("R9 pin blank on", blank_o, 1);
    blank_i = 1'b0;
    @(negedge clk_i);
    chk("R9 pin blank off", blank_o, 0);

    // R11 counter clear
    blank_en_i = 1'b0;
    hpulses(3);
    chk("R6 count", line_o, 3);
    ctr_rst_i = 1'b1; @(negedge clk_i); @(negedge clk_i);
    chk("R11 held high", line_o, 3);
    ctr_rst_i = 1'b0; @(negedge clk_i);
    chk("R11 cleared", line_o, 0);

    // R10 R8 NTSC
    hpulses(19);
    chk("R10 ntsc line19 blank", blank_o, 1);
    hpulse();
    chk("R10 ntsc line20 blank", blank_o, 0);
    hpulses(242);
    chk("R10 ntsc line262 blank", blank_o, 0);
    hpulse();
    chk("R10 ntsc line263 blank", blank_o, 1);
    hpulses(19);
    chk("R10 ntsc line282 blank", blank_o, 1);
    hpulse();
    chk("R10 ntsc line283 blank", blank_o, 0);
    hpulses(241);
    chk("R8 ntsc last", line_o, 524);
    hpulse();
    chk("R8 ntsc wrap", line_o, 0);

    // R10 R8 PAL
    pal_i = 1'b1;
    hpulses(24);
    chk("R10 pal line24 blank", blank_o, 1);
    hpulse();
    chk("R10 pal line25 blank", blank_o, 0);
    hpulses(288);
    chk("R10 pal line313 blank", blank_o, 1);
    hpulses(311);
    chk("R8 pal last", line_o, 624);
    hpulse();
    chk("R8 pal wrap", line_o, 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule